// File: doc/BRIEF.md
# Nonvolatile store/recall controller

This block is the control core of a shadowed memory: a volatile byte array paired with a nonvolatile array of the same depth. Four active-low controls drive it: chip select, write strobe, read enable and nonvolatile select. They arrive without a clock relationship, pass through two-flop synchronisers, and are decoded on the system clock. The decoded combination gives one of five actions: an ordinary volatile read, an ordinary volatile write, a bulk save of the whole volatile array into the nonvolatile array, a bulk restore in the other direction, or nothing.

A bulk operation starts only when the decoded combination changes into the save or restore combination. It then runs by itself for a fixed number of clock cycles. While it runs, `busy` is high, the read bus stays off and every input is ignored. A save first erases the nonvolatile array and then copies the volatile array into it one word per cycle. A restore first clears the volatile array and then loads it from the nonvolatile array, which it leaves unchanged. A low-supply flag blocks any save. The data bus is split into a write path, a read path and a read-drive enable. An integrating level turns these into a tri-state pin.

Top module: `nvshadow_ctrl`

## Requirements
- R1: With `ce_n` high (deselected), `rdata_oe`, `mem_rd` and `mem_wr` are low and `rdata` is zero. After reset all three are low and `busy` is low.
- R2: Control code {`ce_n`,`we_n`,`oe_n`,`nve_n`} = 0,1,0,1 is a read. On the third rising edge after the inputs change, `rdata_oe` and `mem_rd` are high and `rdata` holds the byte last written at `addr`. They stay so each cycle while the code is held, following `addr`.
- R3: Code 0,0,x,1 is a write. It stores `wdata` at `addr` and raises `mem_wr` on the third edge. `rdata_oe` and `mem_rd` stay low even when `oe_n` is low.
- R4: Code 0,0,1,0 is a save request. A change into it raises `busy` on the third edge, and `busy` stays high for exactly `STORE_CYC` cycles. The volatile contents are then held in the nonvolatile array.
- R5: Code 0,1,0,0 is a restore request. It keeps `busy` high for exactly `RECALL_CYC` cycles. Afterwards every volatile word equals the nonvolatile word, and a later restore gives the same contents again, because the nonvolatile array is unchanged.
- R6: If a save or restore code is still held when `busy` falls, no second operation starts.
- R7: While `busy` is high, `rdata_oe`, `mem_rd` and `mem_wr` are low, and write or read codes applied then change no stored word.
- R8: While `low_supply` is high, a change into the save code starts nothing. Releasing `low_supply` with the code still held starts nothing either.
- R9: If a read code is present when `busy` falls, `rdata_oe` rises on the following rising edge with the restored data.
- R10: The codes 0,0,0,0 and 0,1,1,x are no-operations: no strobe, no bus drive, no bulk operation, no change to stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read enable, active low |
| nve_n | input | 1 | Nonvolatile select, active low |
| low_supply | input | 1 | High while the supply is too low to save |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, zero when not driving |
| rdata_oe | output | 1 | Read bus drive enable |
| busy | output | 1 | Bulk save or restore in progress |
| mem_rd | output | 1 | Read access strobe |
| mem_wr | output | 1 | Write access strobe |

## Verification
Every control, address and data input passes through two synchroniser stages and one output register. A read, write or strobe result is therefore due on the third rising edge after an input change. The bench drives inputs on falling edges and samples one falling edge after that third edge. `busy` rises on the same third edge and is measured by counting the falling edges at which it is high, which must equal the configured duration. The read result after a bulk operation is due one edge after `busy` falls, and the bench samples exactly one falling edge later.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  // decoded action of the four active-low controls
  typedef enum logic [2:0] {
    M_IDLE   = 3'd0,
    M_READ   = 3'd1,
    M_WRITE  = 3'd2,
    M_STORE  = 3'd3,
    M_RECALL = 3'd4,
    M_NOP    = 3'd5
  } nvs_mode_e;

endpackage

// File: rtl/nvs_sync.sv
module nvs_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= RST_VAL;
      stage2_q <= RST_VAL;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;

endmodule

// File: rtl/nvs_mode_dec.sv
module nvs_mode_dec
  import nvs_pkg::*;
(
  input  logic      ce_n,
  input  logic      we_n,
  input  logic      oe_n,
  input  logic      nve_n,
  output nvs_mode_e mode
);

  always_comb begin
    mode = M_NOP;
    if (ce_n) begin
      mode = M_IDLE;
    end else if (nve_n) begin
      if (!we_n)      mode = M_WRITE;
      else if (!oe_n) mode = M_READ;
      else            mode = M_NOP;
    end else begin
      if (!we_n && oe_n)      mode = M_STORE;
      else if (we_n && !oe_n) mode = M_RECALL;
      else                    mode = M_NOP;
    end
  end

endmodule

// File: rtl/nvs_bulk.sv
module nvs_bulk #(
  parameter int DEPTH      = 64,
  parameter int IDX_W      = 6,
  parameter int STORE_CYC  = 100,
  parameter int RECALL_CYC = 70
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_store,
  input  logic             start_recall,
  output logic             busy,
  output logic             op_store,
  output logic             clr_vol,
  output logic             clr_nv,
  output logic             cp_v2nv,
  output logic             cp_nv2v,
  output logic [IDX_W-1:0] idx
);

  localparam int MAX_CYC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] LAST_ST = CNT_W'(STORE_CYC - 1);
  localparam logic [CNT_W-1:0] LAST_RC = CNT_W'(RECALL_CYC - 1);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic             busy_q, busy_d;
  logic             st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_cnt;
  logic             in_copy;

  assign last_cnt = st_q ? LAST_ST : LAST_RC;

  // next-state
  always_comb begin
    busy_d = busy_q;
    st_d   = st_q;
    cnt_d  = cnt_q;
    if (!busy_q) begin
      if (start_store) begin
        busy_d = 1'b1;
        st_d   = 1'b1;
        cnt_d  = '0;
      end else if (start_recall) begin
        busy_d = 1'b1;
        st_d   = 1'b0;
        cnt_d  = '0;
      end
    end else if (cnt_q == last_cnt) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      st_q   <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      st_q   <= st_d;
      cnt_q  <= cnt_d;
    end
  end

  // phase 0 clears the target, phases 1..DEPTH copy one word each
  assign in_copy  = busy_q && (cnt_q != '0) && (cnt_q <= DEPTH_C);
  assign clr_nv   = busy_q &&  st_q && (cnt_q == '0);
  assign clr_vol  = busy_q && !st_q && (cnt_q == '0);
  assign cp_v2nv  = in_copy &&  st_q;
  assign cp_nv2v  = in_copy && !st_q;
  assign idx      = IDX_W'(cnt_q - CNT_W'(1));
  assign busy     = busy_q;
  assign op_store = st_q;

endmodule

// File: rtl/nvs_arrays.sv
module nvs_arrays #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              clr_vol,
  input  logic              clr_nv,
  input  logic              cp_v2nv,
  input  logic              cp_nv2v,
  input  logic [ADDR_W-1:0] idx
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] vol_mem [DEPTH];
  logic [DATA_W-1:0] nv_mem  [DEPTH];

  // volatile array: bulk clear, bulk load, or single write
  always_ff @(posedge clk) begin
    if (clr_vol) begin
      for (int i = 0; i < DEPTH; i++) vol_mem[i] <= '0;
    end else if (cp_nv2v) begin
      vol_mem[idx] <= nv_mem[idx];
    end else if (wr_en) begin
      vol_mem[wr_addr] <= wr_data;
    end
  end

  // nonvolatile array: bulk erase, then word-by-word program
  always_ff @(posedge clk) begin
    if (clr_nv) begin
      for (int i = 0; i < DEPTH; i++) nv_mem[i] <= '0;
    end else if (cp_v2nv) begin
      nv_mem[idx] <= vol_mem[idx];
    end
  end

  assign rd_data = vol_mem[rd_addr];

endmodule

// File: rtl/nvshadow_ctrl.sv
module nvshadow_ctrl
  import nvs_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 8,
  parameter int STORE_CYC  = 100,
  parameter int RECALL_CYC = 70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              nve_n,
  input  logic              low_supply,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              busy,
  output logic              mem_rd,
  output logic              mem_wr
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int DS_W  = 1 + ADDR_W + DATA_W;

  // reset: asserted asynchronously, released on the clock
  logic rst_q1, rst_q2, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end
  assign rst_i = rst_q2;

  // input synchronisers
  logic [3:0]        ctl_s;
  logic [DS_W-1:0]   dat_s;
  logic              low_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] wdata_s;

  nvs_sync #(.W(4), .RST_VAL(4'hF)) u_ctl_sync (
    .clk   (clk),
    .rst_n (rst_i),
    .d     ({ce_n, we_n, oe_n, nve_n}),
    .q     (ctl_s)
  );

  nvs_sync #(.W(DS_W), .RST_VAL('0)) u_dat_sync (
    .clk   (clk),
    .rst_n (rst_i),
    .d     ({low_supply, addr, wdata}),
    .q     (dat_s)
  );

  assign {low_s, addr_s, wdata_s} = dat_s;

  // mode decode and transition detect
  nvs_mode_e mode, mode_q;

  nvs_mode_dec u_dec (
    .ce_n  (ctl_s[3]),
    .we_n  (ctl_s[2]),
    .oe_n  (ctl_s[1]),
    .nve_n (ctl_s[0]),
    .mode  (mode)
  );

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) mode_q <= M_IDLE;
    else        mode_q <= mode;
  end

  logic bulk_busy, op_store;
  logic start_store, start_recall;
  logic clr_vol, clr_nv, cp_v2nv, cp_nv2v;
  logic [ADDR_W-1:0] bulk_idx;

  assign start_store  = (mode == M_STORE)  && (mode_q != M_STORE)  && !bulk_busy && !low_s;
  assign start_recall = (mode == M_RECALL) && (mode_q != M_RECALL) && !bulk_busy;

  nvs_bulk #(
    .DEPTH      (DEPTH),
    .IDX_W      (ADDR_W),
    .STORE_CYC  (STORE_CYC),
    .RECALL_CYC (RECALL_CYC)
  ) u_bulk (
    .clk          (clk),
    .rst_n        (rst_i),
    .start_store  (start_store),
    .start_recall (start_recall),
    .busy         (bulk_busy),
    .op_store     (op_store),
    .clr_vol      (clr_vol),
    .clr_nv       (clr_nv),
    .cp_v2nv      (cp_v2nv),
    .cp_nv2v      (cp_nv2v),
    .idx          (bulk_idx)
  );

  // single-word access
  logic              rd_en, wr_en;
  logic [DATA_W-1:0] arr_rd;

  assign rd_en = (mode == M_READ)  && !bulk_busy;
  assign wr_en = (mode == M_WRITE) && !bulk_busy;

  nvs_arrays #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (addr_s),
    .wr_data (wdata_s),
    .rd_addr (addr_s),
    .rd_data (arr_rd),
    .clr_vol (clr_vol),
    .clr_nv  (clr_nv),
    .cp_v2nv (cp_v2nv),
    .cp_nv2v (cp_nv2v),
    .idx     (bulk_idx)
  );

  // output registers
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              oe_q, rd_q, wr_q;

  assign rdata_d = rd_en ? arr_rd : '0;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      rdata_q <= '0;
      oe_q    <= 1'b0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      oe_q    <= rd_en;
      rd_q    <= rd_en;
      wr_q    <= wr_en;
    end
  end

  assign rdata    = rdata_q;
  assign rdata_oe = oe_q;
  assign mem_rd   = rd_q;
  assign mem_wr   = wr_q;
  assign busy     = bulk_busy;

endmodule

// File: rtl/nvs_chk.sv
module nvs_chk #(
  parameter int STORE_CYC  = 100,
  parameter int RECALL_CYC = 70
) (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic busy,
  input logic op_store,
  input logic low_s,
  input logic rdata_oe,
  input logic mem_rd,
  input logic mem_wr
);

  logic [1:0] since_rst;
  int         run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) && $past(ce_n, 3) |-> !rdata_oe && !mem_rd && !mem_wr); // R1

  AST_SINGLE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr, busy})); // R3

  AST_STORE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && op_store |-> run_len == STORE_CYC); // R4

  AST_RECALL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !op_store |-> run_len == RECALL_CYC); // R5

  AST_BUSY_BUS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rdata_oe && !mem_wr && !mem_rd); // R7

  AST_LOW_SUPPLY_VETO: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0) && $rose(busy) && op_store |-> !$past(low_s)); // R8

endmodule

bind nvshadow_ctrl nvs_chk #(
  .STORE_CYC  (STORE_CYC),
  .RECALL_CYC (RECALL_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ce_n     (ce_n),
  .busy     (busy),
  .op_store (op_store),
  .low_s    (low_s),
  .rdata_oe (rdata_oe),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr)
);

// File: tb/nvshadow_ctrl_tb.sv
module nvshadow_ctrl_tb;

  localparam int ADDR_W     = 6;
  localparam int DATA_W     = 8;
  localparam int STORE_CYC  = 100;
  localparam int RECALL_CYC = 70;
  localparam int DEPTH      = 1 << ADDR_W;

  // control codes {ce_n, we_n, oe_n, nve_n}
  localparam logic [3:0] C_DESEL  = 4'b1111;
  localparam logic [3:0] C_READ   = 4'b0101;
  localparam logic [3:0] C_WRITE  = 4'b0011;
  localparam logic [3:0] C_WR_OE  = 4'b0001;
  localparam logic [3:0] C_STORE  = 4'b0010;
  localparam logic [3:0] C_RECALL = 4'b0100;
  localparam logic [3:0] C_NOP0   = 4'b0000;
  localparam logic [3:0] C_NOP1   = 4'b0111;

  // {ctl, addr, wdata, exp_oe, exp_wr, exp_data}
  localparam int NV = 8;
  localparam logic [27:0] VEC [NV] = '{
    {C_WRITE, 6'd10, 8'h55, 1'b0, 1'b1, 8'h00},
    {C_WRITE, 6'd11, 8'hAA, 1'b0, 1'b1, 8'h00},
    {C_WR_OE, 6'd63, 8'hC3, 1'b0, 1'b1, 8'h00},
    {C_READ,  6'd10, 8'h00, 1'b1, 1'b0, 8'h55},
    {C_READ,  6'd11, 8'h00, 1'b1, 1'b0, 8'hAA},
    {C_READ,  6'd63, 8'h00, 1'b1, 1'b0, 8'hC3},
    {C_DESEL, 6'd10, 8'h00, 1'b0, 1'b0, 8'h00},
    {C_NOP1,  6'd10, 8'h00, 1'b0, 1'b0, 8'h00}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ce_n, we_n, oe_n, nve_n, low_supply;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;
  logic              rdata_oe, busy, mem_rd, mem_wr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  nvshadow_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .nve_n(nve_n), .low_supply(low_supply), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe), .busy(busy), .mem_rd(mem_rd),
    .mem_wr(mem_wr)
  );

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(logic [3:0] c, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    @(negedge clk);
    {ce_n, we_n, oe_n, nve_n} = c;
    addr  = a;
    wdata = d;
  endtask

  // three edges for sync + output register, then sample off the edge
  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_write(int a, logic [7:0] d);
    drive(C_WRITE, ADDR_W'(a), d);
    settle();
  endtask

  task automatic do_read(int a, logic [7:0] exp, string req);
    drive(C_READ, ADDR_W'(a), '0);
    settle();
    chk({req, " read enable"}, {31'd0, rdata_oe}, 32'd1);
    chk({req, " read data"}, {24'd0, rdata}, {24'd0, exp});
  endtask

  // start an operation and return how many cycles busy stayed high
  task automatic run_op(logic [3:0] c, output int len);
    int t;
    drive(c, '0, '0);
    t = 0;
    while (!busy && t < 10) begin @(negedge clk); t++; end
    len = 0;
    while (busy && len < 1000) begin len++; @(negedge clk); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int len;
    int bad;
    logic seen;
    rst_n = 1'b0;
    {ce_n, we_n, oe_n, nve_n} = C_DESEL;
    low_supply = 1'b0;
    addr = '0;
    wdata = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R1 reset state
    chk("R1 reset rdata_oe", {31'd0, rdata_oe}, 32'd0);
    chk("R1 reset busy", {31'd0, busy}, 32'd0);
    chk("R1 reset strobes", {30'd0, mem_rd, mem_wr}, 32'd0);

    // vector table: R2 read, R3 write, R1 deselect, R10 no-op
    for (int v = 0; v < NV; v++) begin
      drive(VEC[v][27:24], VEC[v][23:18], VEC[v][17:10]);
      settle();
      chk($sformatf("R2/R3/R10 vec%0d rdata_oe", v), {31'd0, rdata_oe}, {31'd0, VEC[v][9]});
      chk($sformatf("R2 vec%0d mem_rd", v), {31'd0, mem_rd}, {31'd0, VEC[v][9]});
      chk($sformatf("R3 vec%0d mem_wr", v), {31'd0, mem_wr}, {31'd0, VEC[v][8]});
      chk($sformatf("R1/R2 vec%0d rdata", v), {24'd0, rdata}, {24'd0, VEC[v][7:0]});
    end

    // fill the volatile array
    for (int i = 0; i < DEPTH; i++) do_write(i, pat(i));
    do_read(37, pat(37), "R2");

    // R4 save, R6 no retrigger while held
    run_op(C_STORE, len);
    chk("R4 store busy length", len, STORE_CYC);
    seen = 1'b0;
    repeat (20) begin @(negedge clk); seen |= busy; end
    chk("R6 held store no retrigger", {31'd0, seen}, 32'd0);
    drive(C_DESEL, '0, '0);
    settle();

    // overwrite volatile with the complement
    for (int i = 0; i < DEPTH; i++) do_write(i, ~pat(i));
    do_read(3, ~pat(3), "R3");

    // R5 restore, R7 inputs ignored while busy, R9 read at end
    drive(C_RECALL, '0, '0);
    while (!busy) @(negedge clk);
    len = 0;
    seen = 1'b0;
    while (busy && len < 1000) begin
      len++;
      seen |= rdata_oe | mem_wr | mem_rd;
      if (len == 5)  begin {ce_n, we_n, oe_n, nve_n} = C_WRITE; addr = 6'd5; wdata = 8'hEE; end
      if (len == 20) begin {ce_n, we_n, oe_n, nve_n} = C_READ;  addr = 6'd9; end
      @(negedge clk);
    end
    chk("R5 recall busy length", len, RECALL_CYC);
    chk("R7 bus quiet while busy", {31'd0, seen}, 32'd0);
    @(negedge clk);
    chk("R9 read enable after busy", {31'd0, rdata_oe}, 32'd1);
    chk("R9 read data after busy", {24'd0, rdata}, {24'd0, pat(9)});
    do_read(5, pat(5), "R7");
    bad = 0;
    for (int i = 0; i < DEPTH; i++) begin
      drive(C_READ, ADDR_W'(i), '0);
      settle();
      if (rdata !== pat(i)) bad++;
    end
    chk("R5 all words restored", bad, 0);

    // R5 nonvolatile unchanged by restore
    do_write(0, 8'h00);
    drive(C_DESEL, '0, '0);
    settle();
    run_op(C_RECALL, len);
    do_read(0, pat(0), "R5");

    // R8 low supply veto
    do_write(1, 8'h5A);
    low_supply = 1'b1;
    drive(C_DESEL, '0, '0);
    settle();
    drive(C_STORE, '0, '0);
    seen = 1'b0;
    repeat (12) begin @(negedge clk); seen |= busy; end
    chk("R8 store vetoed while low", {31'd0, seen}, 32'd0);
    low_supply = 1'b0;
    seen = 1'b0;
    repeat (12) begin @(negedge clk); seen |= busy; end
    chk("R8 no store on supply release", {31'd0, seen}, 32'd0);
    drive(C_DESEL, '0, '0);
    settle();
    run_op(C_RECALL, len);
    do_read(1, pat(1), "R8");

    // R10 no-operation codes
    drive(C_NOP0, 6'd2, 8'h77);
    settle();
    seen = 1'b0;
    repeat (6) begin @(negedge clk); seen |= busy | rdata_oe | mem_wr | mem_rd; end
    drive(C_NOP1, 6'd2, 8'h77);
    settle();
    repeat (6) begin @(negedge clk); seen |= busy | rdata_oe | mem_wr | mem_rd; end
    chk("R10 no-op codes quiet", {31'd0, seen}, 32'd0);
    do_read(2, pat(2), "R10");

    // R1 deselect after activity
    drive(C_DESEL, 6'd2, '0);
    settle();
    chk("R1 deselect bus off", {31'd0, rdata_oe}, 32'd0);
    chk("R1 deselect rdata zero", {24'd0, rdata}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule